// File: doc/BRIEF.md
# Flash in-system programming controller

This block lets software reprogram an on-chip flash array while the system runs. It has a small register file, a command sequencer and a word-addressed flash model. Software loads an address, a data word and a command code, then writes a start bit. The sequencer runs the command over a fixed number of cycles. Read-type commands update the data register. The busy bit clears when the command is done.

The flash is split into four regions of whole 512-byte pages, in this order from address 0: application, loader, security and configuration. Each region has an update-enable bit in the control register. A command is checked when it is triggered. If it is refused, the array is left untouched and a sticky fail flag is set. A command is refused when it is disallowed, when its code is unsupported, or when its address is out of range or badly aligned.

Top module: `flash_isp_ctrl`

## Requirements
- R1: After reset, every register reads zero: control, address, data, command, trigger and status.
- R2: Writing a value with bit 0 set to the trigger register (select 4) while idle launches the command. The busy bit reads 1 from the next cycle, in trigger bit 0 and status bit 0. It stays 1 for 2 cycles for a read, 4 cycles for a program and 128 cycles for a page erase, then returns to 0.
- R3: Command 0x00 (read) at a legal, word-aligned address loads the stored word into the data register (select 2).
- R4: Command 0x21 (program) ANDs the data register into the addressed word, so bits only ever go from 1 to 0.
- R5: Command 0x22 (page erase) at an address with its low 9 bits zero sets every word of that 512-byte page to all ones. No other page changes.
- R6: Command 0x04 returns ID word i, where i is address bits [3:2] (default 0x5AA5_000i). Command 0x0B returns 0x0000_00DA.
- R7: A trigger while the control enable bit (control bit 0) is 0 sets the fail flag. Busy never rises and nothing else changes.
- R8: Control bit 1 selects the running region: 0 means application, 1 means loader. A program or erase is refused, and sets the fail flag, in four cases:
  - the target is the application region while running from application and control bit 3 is 0;
  - the target is the loader region while running from loader and control bit 5 is 0;
  - the target is the security region and control bit 2 is 0;
  - the target is the configuration region and control bit 4 is 0.
- R9: A command is refused, and sets the fail flag, in any of these cases:
  - a read, program or erase address has bits [1:0] not 00;
  - the address is at or beyond the end of the array (0xA00 by default);
  - an erase address is not page aligned;
  - the command code is not one of 0x00, 0x04, 0x0B, 0x21 or 0x22.
- R10: The fail flag reads in control bit 6 and status bit 6 and stays set. Writing control with bit 6 at 1 clears it; writing bit 6 at 0 leaves it unchanged.
- R11: While busy, writes to the control, address, data, command and trigger registers are ignored. The fail-flag clear still takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 control, 1 address, 2 data, 3 command, 4 trigger, 5 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |

## Verification
The assertions assume that the write strobe and select inputs are clean and known on every clock edge after reset. They also assume that a trigger arrives only through a single-cycle write. The stimulus drives all inputs at the falling edge and holds the strobe for exactly one cycle. It starts a new command only after polling busy back to 0, except in the test of writes made during a busy phase. Before any location is read, the bench erases its page, so no read returns an uninitialised array word.

// File: rtl/flash_isp_ctrl.sv
module flash_isp_ctrl #(
  parameter int APP_PAGES  = 2,
  parameter int LDR_PAGES  = 1,
  parameter int SEC_PAGES  = 1,
  parameter int CFG_PAGES  = 1,
  parameter int PAGE_BYTES = 512,
  parameter int RD_LAT     = 2,
  parameter int PG_LAT     = 4,
  parameter logic [127:0] UID = 128'h5AA5_0003_5AA5_0002_5AA5_0001_5AA5_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata
);
  localparam int PAGES       = APP_PAGES + LDR_PAGES + SEC_PAGES + CFG_PAGES;
  localparam int PAGE_WORDS  = PAGE_BYTES / 4;
  localparam int WORDS       = PAGES * PAGE_WORDS;
  localparam int TOTAL_BYTES = PAGES * PAGE_BYTES;
  localparam int AW = $clog2(TOTAL_BYTES);
  localparam int PW = $clog2(PAGE_BYTES);
  localparam int CW = $clog2(PAGE_WORDS + RD_LAT + PG_LAT);
  localparam logic [31:0] END_B = 32'(TOTAL_BYTES);
  localparam logic [31:0] LDR_P = 32'(APP_PAGES);
  localparam logic [31:0] SEC_P = 32'(APP_PAGES + LDR_PAGES);
  localparam logic [31:0] CFG_P = 32'(APP_PAGES + LDR_PAGES + SEC_PAGES);

  logic en, bs, sec_ue, app_ue, cfg_ue, ldr_ue, fail, busy;
  logic [31:0] isp_addr, isp_dat;
  logic [5:0]  isp_cmd;
  logic [CW-1:0] cnt;
  logic [31:0] mem [WORDS];

  wire idle_wr = reg_we && !busy;
  wire go      = idle_wr && reg_sel == 3'd4 && reg_wdata[0];
  wire clr     = reg_we && reg_sel == 3'd0 && reg_wdata[6];

  wire is_rd  = isp_cmd == 6'h00;
  wire is_uid = isp_cmd == 6'h04;
  wire is_cid = isp_cmd == 6'h0B;
  wire is_pg  = isp_cmd == 6'h21;
  wire is_er  = isp_cmd == 6'h22;
  wire known  = is_rd | is_uid | is_cid | is_pg | is_er;
  wire modify = is_pg | is_er;

  wire [31:0] page = isp_addr >> PW;
  wire dst_app = page < LDR_P;
  wire dst_ldr = !dst_app && page < SEC_P;
  wire dst_sec = page >= SEC_P && page < CFG_P;
  wire dst_cfg = page >= CFG_P;

  wire addr_bad = (is_rd | modify) &&
                  (isp_addr >= END_B || isp_addr[1:0] != 2'b00 ||
                   (is_er && isp_addr[PW-1:0] != '0));
  wire prot_bad = modify && ((dst_app && !bs && !app_ue) ||
                             (dst_ldr &&  bs && !ldr_ue) ||
                             (dst_sec && !sec_ue) ||
                             (dst_cfg && !cfg_ue));
  wire reject = !en || !known || addr_bad || prot_bad;

  wire [CW-1:0] last = is_er ? CW'(PAGE_WORDS - 1) :
                       modify ? CW'(PG_LAT - 1) : CW'(RD_LAT - 1);
  wire done = busy && cnt == last;

  wire [AW-3:0] widx = isp_addr[AW-1:2];
  wire [AW-3:0] eidx = {isp_addr[AW-1:PW], cnt[PW-3:0]};
  wire [31:0]   uid_w = UID[{isp_addr[3:2], 5'd0} +: 32];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {ldr_ue, cfg_ue, app_ue, sec_ue, bs, en} <= '0;
      fail <= 1'b0;
      busy <= 1'b0;
      cnt <= '0;
      isp_addr <= '0;
      isp_dat <= '0;
      isp_cmd <= '0;
    end else begin
      if (idle_wr && reg_sel == 3'd0) {ldr_ue, cfg_ue, app_ue, sec_ue, bs, en} <= reg_wdata[5:0];
      if (idle_wr && reg_sel == 3'd1) isp_addr <= reg_wdata;
      if (idle_wr && reg_sel == 3'd2) isp_dat <= reg_wdata;
      if (idle_wr && reg_sel == 3'd3) isp_cmd <= reg_wdata[5:0];
      if (clr) fail <= 1'b0;
      if (go) begin
        if (reject) fail <= 1'b1;
        else begin
          busy <= 1'b1;
          cnt <= '0;
        end
      end
      if (busy) begin
        if (done) begin
          busy <= 1'b0;
          if (is_rd)  isp_dat <= mem[widx];
          if (is_uid) isp_dat <= uid_w;
          if (is_cid) isp_dat <= 32'h0000_00DA;
        end else cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (busy && is_er) mem[eidx] <= '1;
    else if (done && is_pg) mem[widx] <= mem[widx] & isp_dat;
  end

  always_comb begin
    case (reg_sel)
      3'd0: reg_rdata = {25'd0, fail, ldr_ue, cfg_ue, app_ue, sec_ue, bs, en};
      3'd1: reg_rdata = isp_addr;
      3'd2: reg_rdata = isp_dat;
      3'd3: reg_rdata = {26'd0, isp_cmd};
      3'd4: reg_rdata = {31'd0, busy};
      3'd5: reg_rdata = {25'd0, fail, 5'd0, busy};
      default: reg_rdata = '0;
    endcase
  end
endmodule

module flash_isp_chk #(
  parameter int RUN_MAX = 128
) (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic [2:0]  reg_sel,
  input logic [31:0] reg_wdata,
  input logic        en,
  input logic        busy,
  input logic        fail,
  input logic [31:0] isp_addr,
  input logic [31:0] isp_dat,
  input logic [5:0]  isp_cmd
);
  logic [15:0] run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= '0;
    else run <= busy ? run + 16'd1 : 16'd0;
  end

  // R2
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_we && reg_sel == 3'd4 && reg_wdata[0]));
  // R2
  run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run <= 16'(RUN_MAX));
  // R7
  disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == 3'd4 && reg_wdata[0] && !busy && !en) |=> (fail && !busy));
  // R10
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !(reg_we && reg_sel == 3'd0 && reg_wdata[6])) |=> fail);
  // R11
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(isp_addr) && $stable(isp_cmd)));
  // R6
  cid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && isp_cmd == 6'h0B) |-> isp_dat == 32'h0000_00DA);
endmodule

bind flash_isp_ctrl flash_isp_chk #(.RUN_MAX(PAGE_WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .en(en), .busy(busy), .fail(fail),
  .isp_addr(isp_addr), .isp_dat(isp_dat), .isp_cmd(isp_cmd));

// File: tb/flash_isp_ctrl_tb.sv
module flash_isp_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_sel = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  int nvec = 0;
  int nerr = 0;

  always #5 clk = ~clk;

  flash_isp_ctrl u_dut (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
                        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  typedef struct packed {
    logic [7:0]  ctrl;
    logic [7:0]  cmd;
    logic [31:0] addr;
    logic [31:0] wdat;
    logic        fail;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VEC [NV] = '{
    '{8'h7D, 8'h22, 32'h000, 32'h0, 1'b0, 32'h0},          // R5 erase page 0
    '{8'h7D, 8'h00, 32'h010, 32'h0, 1'b0, 32'hFFFF_FFFF},  // R3
    '{8'h7D, 8'h21, 32'h010, 32'h1234_5678, 1'b0, 32'h1234_5678}, // R4
    '{8'h7D, 8'h00, 32'h010, 32'h0, 1'b0, 32'h1234_5678},  // R3
    '{8'h7D, 8'h21, 32'h010, 32'hFF00_FF00, 1'b0, 32'hFF00_FF00}, // R4
    '{8'h7D, 8'h00, 32'h010, 32'h0, 1'b0, 32'h1200_5600},  // R4 AND result
    '{8'h7D, 8'h00, 32'h014, 32'h0, 1'b0, 32'hFFFF_FFFF},  // R4 neighbour intact
    '{8'h7D, 8'h22, 32'h200, 32'h0, 1'b0, 32'h0},          // R5 erase page 1
    '{8'h7D, 8'h00, 32'h010, 32'h0, 1'b0, 32'h1200_5600},  // R5 other page kept
    '{8'h7D, 8'h00, 32'h204, 32'h0, 1'b0, 32'hFFFF_FFFF},  // R5
    '{8'h7D, 8'h04, 32'h008, 32'h0, 1'b0, 32'h5AA5_0002},  // R6
    '{8'h7D, 8'h04, 32'h000, 32'h0, 1'b0, 32'h5AA5_0000},  // R6
    '{8'h7D, 8'h0B, 32'h000, 32'h0, 1'b0, 32'h0000_00DA},  // R6
    '{8'h41, 8'h21, 32'h020, 32'h0, 1'b1, 32'h0},          // R8 app from app
    '{8'h7D, 8'h00, 32'h020, 32'h0, 1'b0, 32'hFFFF_FFFF},  // R8 unchanged
    '{8'h43, 8'h21, 32'h020, 32'h0, 1'b0, 32'h0},          // R8 app from loader
    '{8'h7D, 8'h00, 32'h020, 32'h0, 1'b0, 32'h0},          // R8
    '{8'h43, 8'h22, 32'h400, 32'h0, 1'b1, 32'h0},          // R8 loader from loader
    '{8'h41, 8'h22, 32'h400, 32'h0, 1'b0, 32'h0},          // R8 loader from app
    '{8'h7D, 8'h00, 32'h404, 32'h0, 1'b0, 32'hFFFF_FFFF},  // R8
    '{8'h41, 8'h21, 32'h600, 32'h0, 1'b1, 32'h0},          // R8 security locked
    '{8'h45, 8'h22, 32'h600, 32'h0, 1'b0, 32'h0},          // R8 security open
    '{8'h41, 8'h21, 32'h800, 32'h0, 1'b1, 32'h0},          // R8 config locked
    '{8'h51, 8'h22, 32'h800, 32'h0, 1'b0, 32'h0},          // R8 config open
    '{8'h7D, 8'h00, 32'h804, 32'h0, 1'b0, 32'hFFFF_FFFF},  // R8
    '{8'h7D, 8'h00, 32'h012, 32'h0, 1'b1, 32'h0},          // R9 misaligned
    '{8'h7D, 8'h00, 32'hA00, 32'h0, 1'b1, 32'h0},          // R9 out of range
    '{8'h7D, 8'h22, 32'h010, 32'h0, 1'b1, 32'h0},          // R9 erase unaligned
    '{8'h7D, 8'h2D, 32'h000, 32'h0, 1'b1, 32'h0},          // R9 unsupported code
    '{8'h7C, 8'h00, 32'h010, 32'h0, 1'b1, 32'h0},          // R7 disabled
    '{8'h7D, 8'h00, 32'h010, 32'h0, 1'b0, 32'h1200_5600}   // R7 nothing changed
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] v);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = s; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [31:0] v);
    reg_sel = s;
    #1;
    v = reg_rdata;
  endtask

  task automatic busy_len(output int n);
    logic [31:0] v;
    n = 0;
    rd(3'd4, v);
    while (v[0] && n < 1000) begin
      n++;
      @(negedge clk);
      rd(3'd4, v);
    end
  endtask

  task automatic launch(input logic [7:0] c, input logic [7:0] cm,
                        input logic [31:0] a, input logic [31:0] d);
    wr(3'd0, {24'd0, c});
    wr(3'd1, a);
    wr(3'd2, d);
    wr(3'd3, {24'd0, cm});
    wr(3'd4, 32'd1);
  endtask

  initial begin
    #2_000_000;
    nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec + 1, nerr);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int s = 0; s < 6; s++) begin
      rd(3'(s), v);
      chk("R1", v, 32'h0);
    end

    for (int i = 0; i < NV; i++) begin
      launch(VEC[i].ctrl, VEC[i].cmd, VEC[i].addr, VEC[i].wdat);
      busy_len(n);
      rd(3'd5, v);
      chk("R7/R8/R9 fail flag", {31'd0, v[6]}, {31'd0, VEC[i].fail});
      rd(3'd2, v);
      chk("R3/R4/R5/R6 data", v, VEC[i].exp);
    end

    // R2 busy lengths
    launch(8'h7D, 8'h22, 32'h200, 32'h0);
    busy_len(n);
    chk("R2 erase busy", 32'(n), 32'd128);
    launch(8'h7D, 8'h00, 32'h200, 32'h0);
    busy_len(n);
    chk("R2 read busy", 32'(n), 32'd2);
    launch(8'h7D, 8'h21, 32'h200, 32'h0F0F_0F0F);
    busy_len(n);
    chk("R2 program busy", 32'(n), 32'd4);

    // R11 writes while busy are ignored
    launch(8'h7D, 8'h22, 32'h200, 32'h0);
    wr(3'd1, 32'h0000_0123);
    wr(3'd3, 32'h0000_0021);
    busy_len(n);
    rd(3'd1, v);
    chk("R11 address kept", v, 32'h200);
    rd(3'd3, v);
    chk("R11 command kept", v, 32'h22);
    launch(8'h7D, 8'h00, 32'h200, 32'h0);
    busy_len(n);
    rd(3'd2, v);
    chk("R11 erase completed", v, 32'hFFFF_FFFF);

    // R7 busy never rises on a disabled trigger
    launch(8'h3C, 8'h00, 32'h0, 32'h0);
    rd(3'd4, v);
    chk("R7 busy stays low", v, 32'h0);
    rd(3'd0, v);
    chk("R10 fail set in control", {31'd0, v[6]}, 32'd1);
    // R10 write 0 to the flag keeps it, write 1 clears it
    wr(3'd0, 32'h0000_003D);
    rd(3'd5, v);
    chk("R10 write 0 no effect", {31'd0, v[6]}, 32'd1);
    wr(3'd0, 32'h0000_007D);
    rd(3'd5, v);
    chk("R10 write 1 clears", {31'd0, v[6]}, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule